// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block manages a parameterised set of general-purpose pins, each controlled by its own 32-bit configuration word on a small memory-mapped read/write bus. The configuration word carries the output data bit, a 3-bit mode code, a peripheral mux select, and an interrupt group number. It also holds pull, drive-strength and lock fields, which are stored but have no effect inside the block. One mode value drives the pad as an output. Five mode values sense the input by level or by edge. One value switches sensing off.

Every pad input passes through a two-flop synchroniser. Each pin compares its synchronised level with the value from the previous cycle and raises a pending bit according to its mode. That pending bit goes into the status bank selected by the pin's group field. Each group has one interrupt output, which stays high while any bit in its bank is set. Software reads the banks and clears bits by writing ones.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every configuration word reads 0x0000000E (mode 7, data bit showing the live pin level of 0), every pending bank reads 0, and all interrupt and output-enable outputs are low.
- R2: Pin n's configuration word is at byte address 4*n. The field layout is: data bit 0, mode bits 3:1, peripheral select bits 6:5, pull bits 8:7, input enable bit 9, drive fields bits 11:10 and 23:22, group bits 18:16, lock bit 21. Only these bits are stored; all other bits read as 0, so writing all ones reads back 0x00E70FEF apart from bit 0.
- R3: In mode 1 a read of bit 0 returns the stored data bit. In any other mode it returns the pin level after two synchronising flops.
- R4: Mode 2 (level high) and mode 3 (level low) set the pending bit on every cycle the synchronised level is active. While the level stays active, a clear write leaves the bit reading 1.
- R5: Mode 4 sets the pending bit on a synchronised rising edge, mode 5 on a falling edge, and mode 6 on either edge. The opposite edge in modes 4 and 5 sets nothing. Edge pending bits stay set until cleared.
- R6: Modes 0, 1 and 7 raise no new events. Switching a pin to one of these modes leaves its existing pending bits unchanged.
- R7: The pending word for group g and pins 32k..32k+31 is at byte address 0x800 + 0x40*g + 4*k, with the pin at bit (pin mod 32). A pin whose group field is NUM_GROUPS or larger raises no pending bit.
- R8: Writing a 1 to a pending bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as its clear wins.
- R9: Interrupt output g is high exactly while any pending bit of group g is set.
- R10: Output enable for pin n is high only when its mode is 1 and its peripheral select is 0; the pad output then carries the data bit.
- R11: Read data and its valid strobe appear one cycle after a read request. Addresses that map neither to a pin word nor to an existing bank read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad output values |
| irq_out | output | NUM_GROUPS | One interrupt per group |

## Verification
The bench targets the points where level and edge sensing differ. It clears a level-high bit while the level is still active and expects the bit to stay set; a design that let the clear win would report a lost interrupt. It drives the wrong edge in rising-only mode and switches a pin with a pending bit to the off mode; a decoder mixing up mode codes would set spurious bits, and one that flushed on mode change would drop a real one. It also uses a pin above 31 in a non-zero group and a group number out of range, so a bank address computed wrongly, or a pending bit routed into a missing bank, would show up as the wrong bit or a stray interrupt.

// File: rtl/pinirq_pkg.sv
// Shared definitions for the per-pin GPIO interrupt controller.
// Assumes a 32-bit data bus and one configuration word per pin.
package pinirq_pkg;

    typedef enum logic [2:0] {
        MODE_NONE = 3'd0,
        MODE_OUT  = 3'd1,
        MODE_HIGH = 3'd2,
        MODE_LOW  = 3'd3,
        MODE_RISE = 3'd4,
        MODE_FALL = 3'd5,
        MODE_ANY  = 3'd6,
        MODE_OFF  = 3'd7
    } pin_mode_e;

    localparam int DATA_BIT = 0;
    localparam int MODE_LSB = 1;
    localparam int SEL_LSB  = 5;
    localparam int GRP_LSB  = 16;

    localparam logic [31:0] CFG_MASK  = 32'h00E7_0FEF;
    localparam logic [31:0] CFG_RESET = 32'h0000_000E;

    // Event for one pin from its mode, current and previous synchronised level.
    function automatic logic sense_event(pin_mode_e m, logic cur, logic prev);
        logic e;
        case (m)
            MODE_HIGH: e = cur;
            MODE_LOW:  e = !cur;
            MODE_RISE: e = cur && !prev;
            MODE_FALL: e = !cur && prev;
            MODE_ANY:  e = cur != prev;
            default:   e = 1'b0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pinirq_sync.sv
// Two-flop synchroniser for all pad inputs plus one history flop per pin.
// Assumes pad_in is asynchronous; lvl_o is the safe level, prev_o the one before.
module pinirq_sync #(
    parameter int NUM_PINS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] lvl_o,
    output logic [NUM_PINS-1:0] prev_o
);

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] lvl_q;
    logic [NUM_PINS-1:0] prev_q;

    // Shift pad levels through the synchroniser and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/pinirq_detect.sv
// Per-pin event detector: turns mode and synchronised levels into set requests
// routed to the group named by the pin's group field. Groups at or above
// NUM_GROUPS receive nothing.
module pinirq_detect
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS   = 40,
    parameter int NUM_GROUPS = 4
) (
    input  logic [NUM_PINS-1:0][2:0]                mode_i,
    input  logic [NUM_PINS-1:0][2:0]                grp_i,
    input  logic [NUM_PINS-1:0]                     lvl_i,
    input  logic [NUM_PINS-1:0]                     prev_i,
    output logic [NUM_GROUPS-1:0][NUM_PINS-1:0]     set_o
);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic evt;
        // Evaluate the sensing rule selected by this pin's mode.
        assign evt = sense_event(pin_mode_e'(mode_i[n]), lvl_i[n], prev_i[n]);
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign set_o[g][n] = evt && (grp_i[n] == 3'(g));
        end
    end

endmodule

// File: rtl/pinirq_pending.sv
// Pending banks: one bit per group and pin, set by events, cleared by
// write-one requests; a set in the same cycle beats a clear. One interrupt
// output per group, high while any bit of the group is set.
module pinirq_pending #(
    parameter int NUM_PINS   = 40,
    parameter int NUM_GROUPS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] set_i,
    input  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] clr_i,
    output logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend_o,
    output logic [NUM_GROUPS-1:0]               irq_o
);

    logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend_q;

    // Apply clears, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
        end
    end

    // Reduce each bank to its interrupt line.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            irq_o[g] = |pend_q[g];
        end
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[g]) |-> $past(|set_i[g]));
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_bit
            assert_pend_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_q[g][n]) |-> $past(set_i[g][n]));
            assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend_q[g][n]) |-> $past(clr_i[g][n]));
        end
    end

endmodule

// File: rtl/pinirq_ctrl.sv
// GPIO controller top: per-pin configuration words, address decode, registered
// read path, pad output control and the pending/interrupt structure.
// Assumes word-aligned accesses; pin words below 0x800, banks from 0x800.
module pinirq_ctrl
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS   = 40,
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_rvalid,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_GROUPS-1:0] irq_out
);

    localparam int WORDS  = (NUM_PINS + 31) / 32;
    localparam int PIDX_W = ADDR_W - 2;
    localparam int GW     = ADDR_W - 7;
    localparam logic [ADDR_W-1:0] PIN_SPAN  = ADDR_W'(4 * NUM_PINS);
    localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(12'h800);

    logic [31:0]                         cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0][2:0]            pin_mode;
    logic [NUM_PINS-1:0][2:0]            pin_grp;
    logic [NUM_PINS-1:0]                 sync_lvl;
    logic [NUM_PINS-1:0]                 sync_prev;
    logic [NUM_GROUPS-1:0][NUM_PINS-1:0] set_req;
    logic [NUM_GROUPS-1:0][NUM_PINS-1:0] clr_req;
    logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0]                 wr_hit;

    logic              pin_hit;
    logic              pend_hit;
    logic [PIDX_W-1:0] pin_idx;
    logic [ADDR_W-1:0] pend_off;
    logic [GW-1:0]     pend_g;
    logic [3:0]        pend_k;
    logic [31:0]       rd_mux;
    logic [31:0]       rdata_q;
    logic              rvalid_q;

    // Decode the address into a pin word or a pending word.
    always_comb begin
        pin_idx  = bus_addr[ADDR_W-1:2];
        pend_off = bus_addr - PEND_BASE;
        pend_g   = pend_off[ADDR_W-2:6];
        pend_k   = pend_off[5:2];
        pin_hit  = (bus_addr < PIN_SPAN) && (bus_addr[1:0] == 2'b00);
        pend_hit = (bus_addr >= PEND_BASE) && (bus_addr[1:0] == 2'b00) &&
                   (pend_g < GW'(NUM_GROUPS)) && (pend_k < 4'(WORDS));
    end

    // Per-pin write strobes for configuration words.
    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            wr_hit[n] = bus_wr && pin_hit && (pin_idx == PIDX_W'(n));
        end
    end

    // Store the implemented configuration bits of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_PINS; n++) cfg_q[n] <= CFG_RESET;
        end else begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (wr_hit[n]) cfg_q[n] <= bus_wdata & CFG_MASK;
            end
        end
    end

    // Pull mode and group fields out of each configuration word.
    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            pin_mode[n] = cfg_q[n][MODE_LSB +: 3];
            pin_grp[n]  = cfg_q[n][GRP_LSB +: 3];
        end
    end

    // Build write-one-to-clear requests for the addressed bank word.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                clr_req[g][n] = bus_wr && pend_hit && (pend_g == GW'(g)) &&
                                (pend_k == 4'(n / 32)) && bus_wdata[n % 32];
            end
        end
    end

    // Select the word returned for the current read address.
    always_comb begin
        rd_mux = '0;
        if (pin_hit) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (pin_idx == PIDX_W'(n)) begin
                    rd_mux = cfg_q[n];
                    if (pin_mode[n] != MODE_OUT) rd_mux[DATA_BIT] = sync_lvl[n];
                end
            end
        end else if (pend_hit) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                for (int n = 0; n < NUM_PINS; n++) begin
                    if (pend_g == GW'(g) && pend_k == 4'(n / 32))
                        rd_mux[n % 32] = pend[g][n];
                end
            end
        end
    end

    // Register read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
        // Drive the pad only as a plain GPIO output.
        assign pad_oe[n]  = (pin_mode[n] == MODE_OUT) && (cfg_q[n][SEL_LSB +: 2] == 2'b00);
        assign pad_out[n] = pad_oe[n] && cfg_q[n][DATA_BIT];
    end

    pinirq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .lvl_o  (sync_lvl),
        .prev_o (sync_prev)
    );

    pinirq_detect #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_detect (
        .mode_i (pin_mode),
        .grp_i  (pin_grp),
        .lvl_i  (sync_lvl),
        .prev_i (sync_prev),
        .set_o  (set_req)
    );

    pinirq_pending #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_req),
        .clr_i  (clr_req),
        .pend_o (pend),
        .irq_o  (irq_out)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit[n] |=> (cfg_q[n] == ($past(bus_wdata) & CFG_MASK)));
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lvl
            assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_mode[n] == MODE_HIGH && sync_lvl[n] && pin_grp[n] == 3'(g))
                |=> pend[g][n]);
        end
    end

    assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

endmodule

// File: tb/pinirq_ctrl_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them
// against returned read data; pad and interrupt outputs are checked directly.
module pinirq_ctrl_bench;

    localparam int NP = 40;
    localparam int NG = 4;

    typedef struct {
        logic [31:0] exp;
        logic [11:0] addr;
        string       tag;
    } rd_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;
    logic [NG-1:0] irq_out;

    rd_item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pinirq_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG), .ADDR_W(12)) u_pinirq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = e; it.addr = a; it.tag = tag;
        exp_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: pop the oldest expected read and compare with returned data.
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R11 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(8 * 50000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        check("R1 irq_out", 32'(irq_out), 32'h0);
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        bus_read(12'h000, 32'h0000_000E, "R1 pin0 cfg");
        bus_read(12'h09C, 32'h0000_000E, "R1 pin39 cfg");
        bus_read(12'h800, 32'h0, "R1 bank g0");

        // R2 implemented bits only
        bus_write(12'h00C, 32'hFFFF_FFFF);
        bus_read(12'h00C, 32'h00E7_0FEE, "R2 mask readback");
        check("R10 oe off for mode 7", 32'(pad_oe[3]), 32'h0);
        // R10 / R3 output mode
        bus_write(12'h00C, 32'h0000_0003);
        bus_read(12'h00C, 32'h0000_0003, "R3 output data stored");
        check("R10 oe output", 32'(pad_oe[3]), 32'h1);
        check("R10 out value", 32'(pad_out[3]), 32'h1);
        bus_write(12'h00C, 32'h0000_0002);
        check("R10 out zero", 32'(pad_out[3]), 32'h0);
        bus_write(12'h00C, 32'h0000_0023);
        check("R10 alt function no oe", 32'(pad_oe[3]), 32'h0);

        // R3 live level for an input
        pad_in[5] = 1'b1;
        wait_cyc(3);
        bus_read(12'h014, 32'h0000_000F, "R3 live level");

        // R5 rising edge, group 0
        bus_write(12'h018, 32'h0000_0008);
        pad_in[6] = 1'b1;
        wait_cyc(3);
        check("R9 irq0 on rise", 32'(irq_out), 32'h1);
        bus_read(12'h800, 32'h40, "R5 rise pending");
        bus_write(12'h800, 32'h40);
        bus_read(12'h800, 32'h0, "R8 clear edge bit");
        check("R9 irq0 drops", 32'(irq_out), 32'h0);
        pad_in[6] = 1'b0;
        wait_cyc(3);
        bus_read(12'h800, 32'h0, "R5 fall ignored in rise mode");

        // R5/R7 falling edge, group 1
        pad_in[7] = 1'b1;
        wait_cyc(3);
        bus_write(12'h01C, 32'h0001_000A);
        pad_in[7] = 1'b0;
        wait_cyc(3);
        check("R9 only irq1", 32'(irq_out), 32'h2);
        bus_read(12'h840, 32'h80, "R7 group1 bank");
        bus_write(12'h840, 32'h0);
        bus_read(12'h840, 32'h80, "R8 zero write no effect");
        bus_write(12'h840, 32'h80);
        bus_read(12'h840, 32'h0, "R8 clear g1");

        // R5/R7 any edge on pin 33, group 2, bank word 1
        bus_write(12'h084, 32'h0002_000C);
        pad_in[33] = 1'b1;
        wait_cyc(3);
        bus_read(12'h884, 32'h2, "R7 pin33 bank word 1");
        bus_write(12'h884, 32'h2);
        pad_in[33] = 1'b0;
        wait_cyc(3);
        bus_read(12'h884, 32'h2, "R5 any edge falling");
        // R6 switching off keeps pending, then no new events
        bus_write(12'h084, 32'h0002_000E);
        bus_read(12'h884, 32'h2, "R6 pending kept on mode off");
        bus_write(12'h884, 32'h2);
        pad_in[33] = 1'b1;
        wait_cyc(3);
        bus_read(12'h884, 32'h0, "R6 off mode no event");

        // R4 level high, pin 10, group 3
        bus_write(12'h028, 32'h0003_0004);
        bus_read(12'h8C0, 32'h0, "R4 inactive level");
        pad_in[10] = 1'b1;
        wait_cyc(3);
        bus_read(12'h8C0, 32'h400, "R4 high level pending");
        bus_write(12'h8C0, 32'h400);
        bus_read(12'h8C0, 32'h400, "R4 clear while active reasserts");
        check("R9 irq3 high", 32'(irq_out[3]), 32'h1);
        pad_in[10] = 1'b0;
        wait_cyc(3);
        bus_write(12'h8C0, 32'h400);
        bus_read(12'h8C0, 32'h0, "R4 clear after release");
        check("R9 irq3 low", 32'(irq_out[3]), 32'h0);

        // R4 level low, pin 11, group 0
        bus_write(12'h02C, 32'h0000_0006);
        wait_cyc(1);
        bus_read(12'h800, 32'h800, "R4 low level pending");
        pad_in[11] = 1'b1;
        wait_cyc(3);
        bus_write(12'h800, 32'h800);
        bus_read(12'h800, 32'h0, "R4 low released and cleared");

        // R7 group out of range
        bus_write(12'h030, 32'h0005_0008);
        pad_in[12] = 1'b1;
        wait_cyc(3);
        check("R7 no irq for bad group", 32'(irq_out), 32'h0);
        bus_read(12'h800, 32'h0, "R7 bad group drops event");

        // R6 output mode raises nothing
        bus_write(12'h034, 32'h0000_0002);
        pad_in[13] = 1'b1;
        wait_cyc(3);
        bus_read(12'h800, 32'h0, "R6 output mode no event");

        // R11 unmapped addresses
        bus_read(12'h0A0, 32'h0, "R11 pin beyond range");
        bus_read(12'h900, 32'h0, "R11 missing group bank");
        bus_write(12'h404, 32'hFFFF_FFFF);
        bus_read(12'h404, 32'h0, "R11 hole reads zero");
        bus_read(12'h004, 32'h0000_000E, "R11 stray write no effect");

        wait_cyc(3);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R11 reads outstanding actual=%0d expected=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule